// File: doc/BRIEF.md
# Period-Match Timer with Match Postscaler

The block is an 8-bit up-counter driven by a prescaled internal tick. It counts up to a programmable period value. A count tick taken while the counter equals the period returns the counter to zero rather than advancing it. That tick also emits a one-cycle match pulse, which a serial module can use as its shift clock. A postscaler counts these matches and sets a sticky interrupt flag after a programmable number of them.

The surrounding logic writes the counter, the period and the control byte through strobed write ports and can read all three back at any time. The `tickEn` input is the base count strobe, for example one pulse per instruction cycle. While the enable bit in the control byte is clear, the timer and its prescaler both freeze, so the counter logic draws no switching power. Software clears the interrupt flag with `irqClr`.

Top module: `period_match_timer`

## Requirements
- R1: After reset the counter reads 0x00, the period reads 0xFF, the control byte reads 0x00, and `irqFlag` and `matchPulse` are low.
- R2: The control byte is laid out as follows: bits 6:3 hold the postscale code, bit 2 is the enable, and bits 1:0 hold the prescale code. Bit 7 is not implemented and always reads 0, so writing 0xFF reads back as 0x7F.
- R3: With the enable set, the prescale code sets how many `tickEn` cycles make one count tick. Code 00 gives one count tick per `tickEn` cycle, code 01 gives one per 4, and codes 10 and 11 give one per 16.
- R4: On a count tick where the counter differs from the period, the counter rises by one.
- R5: On a count tick where the counter equals the period, the counter becomes 0 and `matchPulse` is high for the following cycle only.
- R6: With postscale code N, `irqFlag` sets on every (N+1)-th match. It stays set until `irqClr`, and a set in the same cycle as `irqClr` wins.
- R7: While the enable is clear, `tickEn` has no effect: the counter and the prescaler phase hold.
- R8: A counter write loads the counter. A write to either the counter or the control byte restarts the prescaler and postscaler counts from zero.
- R9: A period write loads the period, and the new value reads back from the next cycle onward.
- R10: A counter write in the same cycle as a count tick wins, so the written value is loaded without being incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Base count strobe feeding the prescaler |
| wrTimer | input | 1 | Load the counter from wrData |
| wrPeriod | input | 1 | Load the period from wrData |
| wrCtrl | input | 1 | Load the control byte from wrData |
| wrData | input | 8 | Write data |
| irqClr | input | 1 | Clear the interrupt flag |
| timerVal | output | 8 | Counter readback |
| periodVal | output | 8 | Period readback |
| ctrlVal | output | 8 | Control byte readback |
| irqFlag | output | 1 | Sticky interrupt flag |
| matchPulse | output | 1 | One-cycle pulse per period match (shift clock) |

## Verification
The hardest states to reach from the ports are the hidden prescaler and postscaler phases. They show only indirectly, through when the counter next moves or when the flag next rises.

The bench first parks each phase at a known non-zero value. It does this by running an exact number of `tickEn` cycles, then issues a counter write and counts how many further cycles pass before the next step or flag. This shows whether the write restarted the phase.

The set-versus-clear collision on the flag is reached by using a period of 0 with a divide of one, so that every enabled cycle is a match. `irqClr` is then held in the same cycle as that match.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CTRL_W   = 8;
  localparam int PRE_W    = 4;
  localparam int POST_W   = 4;
  localparam int EN_BIT   = 2;
  localparam int POST_LSB = 3;

  typedef struct packed {
    logic cntTick;   // one prescaled count tick this cycle
    logic clrScale;  // restart prescaler and postscaler
  } tmrStrobe_t;

  function automatic logic [PRE_W-1:0] preLimit(input logic [1:0] code);
    case (code)
      2'b00:   preLimit = PRE_W'(0);
      2'b01:   preLimit = PRE_W'(3);
      default: preLimit = PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrCtrl,
  input  logic              wrTimer,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [POST_W-1:0] postCode,
  output tmrStrobe_t        stb
);
  localparam logic [CTRL_W-1:0] CTRL_MASK = {1'b0, {(CTRL_W-1){1'b1}}};

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] limit;
  logic             runOn;
  logic             preWrap;

  assign runOn    = ctrlReg[EN_BIT];
  assign limit    = preLimit(ctrlReg[1:0]);
  assign preWrap  = (preCnt >= limit);
  assign postCode = ctrlReg[POST_LSB +: POST_W];

  always_comb begin
    stb.clrScale = wrCtrl | wrTimer;
    stb.cntTick  = runOn & tickEn & preWrap & ~stb.clrScale;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg <= wrData & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (stb.clrScale) begin
      preCnt <= '0;
    end else if (runOn && tickEn) begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
`timescale 1ns/1ps
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int TW = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrTimer,
  input  logic              wrPeriod,
  input  logic [TW-1:0]     wrData,
  input  logic              irqClr,
  input  tmrStrobe_t        stb,
  input  logic [POST_W-1:0] postCode,
  output logic [TW-1:0]     timerReg,
  output logic [TW-1:0]     periodReg,
  output logic              irqFlag,
  output logic              matchPulse
);
  logic [POST_W-1:0] postCnt;
  logic              isMatch;
  logic              matchEvt;
  logic              postHit;

  assign isMatch  = (timerReg == periodReg);
  assign matchEvt = stb.cntTick & isMatch;
  assign postHit  = matchEvt & (postCnt == postCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerReg <= '0;
    end else if (wrTimer) begin
      timerReg <= wrData;
    end else if (stb.cntTick) begin
      timerReg <= isMatch ? '0 : timerReg + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '1;
    end else if (wrPeriod) begin
      periodReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postCnt <= '0;
    end else if (stb.clrScale) begin
      postCnt <= '0;
    end else if (matchEvt) begin
      postCnt <= postHit ? '0 : postCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag    <= 1'b0;
      matchPulse <= 1'b0;
    end else begin
      matchPulse <= matchEvt;
      if (postHit) begin
        irqFlag <= 1'b1;
      end else if (irqClr) begin
        irqFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/period_match_timer.sv
`timescale 1ns/1ps
module period_match_timer
  import tmr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         wrTimer,
  input  logic         wrPeriod,
  input  logic         wrCtrl,
  input  logic [7:0]   wrData,
  input  logic         irqClr,
  output logic [7:0]   timerVal,
  output logic [7:0]   periodVal,
  output logic [7:0]   ctrlVal,
  output logic         irqFlag,
  output logic         matchPulse
);
  tmrStrobe_t        stb;
  logic [POST_W-1:0] postCode;

  tmr_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .wrCtrl   (wrCtrl),
    .wrTimer  (wrTimer),
    .wrData   (wrData),
    .ctrlReg  (ctrlVal),
    .postCode (postCode),
    .stb      (stb)
  );

  tmr_datapath #(.TW(8)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrTimer    (wrTimer),
    .wrPeriod   (wrPeriod),
    .wrData     (wrData),
    .irqClr     (irqClr),
    .stb        (stb),
    .postCode   (postCode),
    .timerReg   (timerVal),
    .periodReg  (periodVal),
    .irqFlag    (irqFlag),
    .matchPulse (matchPulse)
  );
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int TW = 8
)(
  input logic          clk,
  input logic          rstN,
  input logic          wrTimer,
  input logic          wrPeriod,
  input logic          wrCtrl,
  input logic [TW-1:0] wrData,
  input logic [TW-1:0] timerVal,
  input logic [TW-1:0] periodVal,
  input logic [7:0]    ctrlVal,
  input logic          irqFlag,
  input logic          matchPulse,
  input logic          cntTick
);
  AST_CTRL_LAYOUT: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> ctrlVal == {1'b0, $past(wrData[6:0])}); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cntTick && !wrTimer && timerVal != periodVal) |=> timerVal == TW'($past(timerVal) + 1'b1)); // R4

  AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cntTick && !wrTimer && timerVal == periodVal) |=> (timerVal == '0 && matchPulse)); // R5

  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> matchPulse); // R6

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlVal[2] |-> !cntTick); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlVal[2] && !wrTimer) |=> $stable(timerVal)); // R7

  AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrPeriod |=> periodVal == $past(wrData)); // R9

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wrTimer |=> timerVal == $past(wrData)); // R10
endmodule

bind period_match_timer tmr_checker #(.TW(8)) i_tmrChecker (
  .clk        (clk),
  .rstN       (rstN),
  .wrTimer    (wrTimer),
  .wrPeriod   (wrPeriod),
  .wrCtrl     (wrCtrl),
  .wrData     (wrData),
  .timerVal   (timerVal),
  .periodVal  (periodVal),
  .ctrlVal    (ctrlVal),
  .irqFlag    (irqFlag),
  .matchPulse (matchPulse),
  .cntTick    (stb.cntTick)
);

// File: tb/test_period_match_timer.sv
`timescale 1ns/1ps
module test_period_match_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrTimer = 1'b0;
  logic       wrPeriod = 1'b0;
  logic       wrCtrl = 1'b0;
  logic [7:0] wrData = '0;
  logic       irqClr = 1'b0;
  logic [7:0] timerVal;
  logic [7:0] periodVal;
  logic [7:0] ctrlVal;
  logic       irqFlag;
  logic       matchPulse;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  bit counting = 1'b0;

  always #10 clk = ~clk;

  period_match_timer i_period_match_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrTimer(wrTimer),
    .wrPeriod(wrPeriod), .wrCtrl(wrCtrl), .wrData(wrData), .irqClr(irqClr),
    .timerVal(timerVal), .periodVal(periodVal), .ctrlVal(ctrlVal),
    .irqFlag(irqFlag), .matchPulse(matchPulse)
  );

  always @(negedge clk) if (counting && matchPulse) pulses++;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  per;
    logic [15:0] k;
    logic [7:0]  expT;
    logic [15:0] expM;
    logic        expF;
  } vec_t;

  // expected: T = k / div ticks, matches = T/(per+1), timer = T%(per+1), flag = matches >= post+1
  localparam vec_t VECS [10] = '{
    '{8'h04, 8'd9,   16'd25,  8'd5,  16'd2,  1'b1},
    '{8'h05, 8'd3,   16'd30,  8'd3,  16'd1,  1'b1},
    '{8'h06, 8'd1,   16'd50,  8'd1,  16'd1,  1'b1},
    '{8'h0F, 8'd1,   16'd50,  8'd1,  16'd1,  1'b0},
    '{8'h14, 8'd4,   16'd15,  8'd0,  16'd3,  1'b1},
    '{8'h14, 8'd4,   16'd14,  8'd4,  16'd2,  1'b0},
    '{8'h7C, 8'd0,   16'd16,  8'd0,  16'd16, 1'b1},
    '{8'h7C, 8'd0,   16'd15,  8'd0,  16'd15, 1'b0},
    '{8'h04, 8'd255, 16'd300, 8'd44, 16'd1,  1'b1},
    '{8'h00, 8'd5,   16'd20,  8'd0,  16'd0,  1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input int which, input logic [7:0] d);
    wrData = d;
    if (which == 0) wrTimer = 1'b1;
    else if (which == 1) wrPeriod = 1'b1;
    else wrCtrl = 1'b1;
    step();
    wrTimer = 1'b0; wrPeriod = 1'b0; wrCtrl = 1'b0;
  endtask

  task automatic clearFlag();
    irqClr = 1'b1;
    step();
    irqClr = 1'b0;
  endtask

  task automatic run(input int k);
    pulses = 0;
    counting = 1'b1;
    tickEn = 1'b1;
    repeat (k) step();
    tickEn = 1'b0;
    step();
    step();
    counting = 1'b0;
  endtask

  task automatic setup(input logic [7:0] c, input logic [7:0] p);
    wrReg(1, p);
    wrReg(2, c);
    wrReg(0, 8'd0);
    clearFlag();
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 timer", timerVal, 0);
    chk("R1 period", periodVal, 255);
    chk("R1 ctrl", ctrlVal, 0);
    chk("R1 flag", irqFlag, 0);
    chk("R1 pulse", matchPulse, 0);

    // R2 unused bit reads zero
    wrReg(2, 8'hFF);
    chk("R2 bit7", ctrlVal, 8'h7F);
    wrReg(2, 8'h00);

    // table: R3 prescale, R4/R5 counting and wrap, R6 postscale, R7 disabled
    for (int i = 0; i < 10; i++) begin
      setup(VECS[i].ctrl, VECS[i].per);
      chk("R2 ctrl readback", ctrlVal, VECS[i].ctrl);
      chk("R9 period readback", periodVal, VECS[i].per);
      run(VECS[i].k);
      chk("R3 R4 timer", timerVal, VECS[i].expT);
      chk("R5 match pulses", pulses, VECS[i].expM);
      chk("R6 flag", irqFlag, VECS[i].expF);
    end

    // R6 flag stays set until cleared
    setup(8'h04, 8'd2);
    run(3);
    chk("R6 flag set", irqFlag, 1);
    repeat (5) step();
    chk("R6 flag sticky", irqFlag, 1);
    clearFlag();
    chk("R6 flag cleared", irqFlag, 0);

    // R6 set wins over clear in the same cycle
    setup(8'h04, 8'd0);
    tickEn = 1'b1; irqClr = 1'b1;
    step();
    tickEn = 1'b0;
    chk("R6 set beats clear", irqFlag, 1);
    step();
    irqClr = 1'b0;
    chk("R6 clear alone", irqFlag, 0);

    // R8 counter write restarts the prescaler
    setup(8'h05, 8'hFF);
    run(3);
    chk("R8 no tick yet", timerVal, 0);
    wrReg(0, 8'd10);
    run(3);
    chk("R8 prescaler restarted", timerVal, 10);
    run(1);
    chk("R8 tick after 4", timerVal, 11);

    // R8 counter write restarts the postscaler
    setup(8'h0C, 8'd2);
    run(3);
    chk("R8 first match no flag", irqFlag, 0);
    wrReg(0, 8'd0);
    run(3);
    chk("R8 postscaler restarted", irqFlag, 0);
    run(3);
    chk("R8 second match flags", irqFlag, 1);

    // R7 disable mid-count holds the counter
    setup(8'h04, 8'hFF);
    run(7);
    wrReg(2, 8'h00);
    run(20);
    chk("R7 held", timerVal, 7);

    // R10 write beats a coincident count tick
    setup(8'h04, 8'hFF);
    tickEn = 1'b1; wrTimer = 1'b1; wrData = 8'd50;
    step();
    wrTimer = 1'b0;
    chk("R10 write wins", timerVal, 50);
    step();
    tickEn = 1'b0;
    chk("R10 count resumes", timerVal, 51);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule